// File: doc/BRIEF.md
# Size-Scaled Address Generation Unit

This unit forms effective memory addresses for a 16-bit processor that reads and writes both bytes and words. A base value is added to one of two offsets: a sign-extended immediate field, or an index register. On word accesses the selected offset counts words instead of bytes, so it is doubled before the add. This doubles the reach of a short immediate, and it lets an array subscript index a word array with no separate multiply. Byte accesses add the offset unchanged.

The sum is available combinationally in the same cycle, so an instruction that only computes an address can write it back to a register. No condition flags are affected. A flag marks a word access whose final address is odd. A one-entry output stage keeps a registered copy of the address and the flag for the next pipeline stage, with a valid strobe. That stage is a two-state machine. `ST_EMPTY` moves to `ST_FULL` when an input is valid. `ST_FULL` stays in `ST_FULL` while inputs keep arriving and returns to `ST_EMPTY` on a cycle with no valid input.

Top module: `agu_scaled`

## Requirements
- R1: With `mode_i`=0 (immediate) and `size_i`=0 (byte), `addr_o` equals `base_i` plus the 8-bit `imm_i` sign-extended to 16 bits.
- R2: With `mode_i`=0 and `size_i`=1 (word), `addr_o` equals `base_i` plus the sign-extended immediate shifted left by one bit.
- R3: With `mode_i`=1 (index) and `size_i`=0, `addr_o` equals `base_i` plus `index_i`.
- R4: With `mode_i`=1 and `size_i`=1, `addr_o` equals `base_i` plus `index_i` shifted left by one bit. The shifted-out top bit of the index is dropped.
- R5: `misalign_o` is 1 exactly when `size_i`=1 and bit 0 of `addr_o` is 1. It is 0 for every byte access.
- R6: All additions wrap modulo 2^16. No carry is reported.
- R7: One cycle after a cycle with `in_valid`=1, `valid_q` is 1 and `addr_q` and `misalign_q` equal the values that `addr_o` and `misalign_o` had in that earlier cycle.
- R8: One cycle after a cycle with `in_valid`=0, `valid_q` is 0 and `addr_q` and `misalign_q` keep their previous values.
- R9: While `rst_n` is low and directly after it is released, `valid_q`, `addr_q` and `misalign_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operands in this cycle are to be captured |
| base_i | input | 16 | Base register value |
| index_i | input | 16 | Index register value |
| imm_i | input | 8 | Signed immediate offset field |
| mode_i | input | 1 | 0 = base + immediate, 1 = base + index |
| size_i | input | 1 | 0 = byte access, 1 = word access |
| addr_o | output | 16 | Combinational effective address |
| misalign_o | output | 1 | Combinational odd-word-address flag |
| addr_q | output | 16 | Registered address |
| misalign_q | output | 1 | Registered alignment flag |
| valid_q | output | 1 | Registered copy is valid |

## Verification
Some properties are checked on every clock. The alignment flag may only rise on a word access and only at an odd address. The output stage must follow the valid input, capture the combinational result on a valid cycle and hold it when idle. The arithmetic itself can only be shown by the bench scenarios. These cover sign extension of negative immediates, doubling in both modes, loss of the top index bit, wrap past 0xFFFF, and odd bases under both access sizes, all compared against an independent model.

// File: rtl/agu_pkg.sv
package agu_pkg;
    typedef enum logic {
        MODE_IMM = 1'b0,
        MODE_IDX = 1'b1
    } agu_mode_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } agu_size_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;
endpackage

// File: rtl/agu_offset_sel.sv
module agu_offset_sel
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic [ADDR_W-1:0] index_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  agu_mode_e         mode_i,
    input  agu_size_e         size_i,
    output logic [ADDR_W-1:0] off_o
);
    localparam int EXT_W = (ADDR_W > IMM_W) ? ADDR_W - IMM_W : 1;

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] raw;

    // Sign extension of the immediate to address width
    generate
        if (ADDR_W > IMM_W) begin : g_extend
            assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        end else begin : g_trunc
            assign imm_ext = imm_i[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (mode_i)
            MODE_IMM: raw = imm_ext;
            MODE_IDX: raw = index_i;
        endcase
    end

    // Word accesses count in words: double the offset
    always_comb begin
        unique case (size_i)
            SZ_BYTE: off_o = raw;
            SZ_WORD: off_o = {raw[ADDR_W-2:0], 1'b0};
        endcase
    end
endmodule

// File: rtl/agu_adder.sv
module agu_adder
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] off_i,
    input  agu_size_e         size_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              misalign_o
);
    // Carry out is discarded: wrap modulo 2^ADDR_W
    assign addr_o     = base_i + off_i;
    assign misalign_o = (size_i == SZ_WORD) && addr_o[0];
endmodule

// File: rtl/agu_stage.sv
module agu_stage
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              mis_d,
    output logic [ADDR_W-1:0] addr_q,
    output logic              mis_q,
    output logic              valid_q
);
    stage_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_EMPTY: state_nx = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_nx = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            mis_q  <= 1'b0;
        end else if (in_valid) begin
            addr_q <= addr_d;
            mis_q  <= mis_d;
        end
    end

    assign valid_q = (state == ST_FULL);

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> valid_q);
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (addr_q == $past(addr_d)) && (mis_q == $past(mis_d)));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !valid_q && $stable(addr_q) && $stable(mis_q));
endmodule

// File: rtl/agu_scaled.sv
module agu_scaled
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] index_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              mode_i,
    input  logic              size_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              misalign_o,
    output logic [ADDR_W-1:0] addr_q,
    output logic              misalign_q,
    output logic              valid_q
);
    agu_mode_e         mode;
    agu_size_e         size;
    logic [ADDR_W-1:0] off;

    assign mode = agu_mode_e'(mode_i);
    assign size = agu_size_e'(size_i);

    agu_offset_sel #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_off (
        .index_i (index_i),
        .imm_i   (imm_i),
        .mode_i  (mode),
        .size_i  (size),
        .off_o   (off)
    );

    agu_adder #(.ADDR_W(ADDR_W)) u_add (
        .base_i     (base_i),
        .off_i      (off),
        .size_i     (size),
        .addr_o     (addr_o),
        .misalign_o (misalign_o)
    );

    agu_stage #(.ADDR_W(ADDR_W)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .addr_d   (addr_o),
        .mis_d    (misalign_o),
        .addr_q   (addr_q),
        .mis_q    (misalign_q),
        .valid_q  (valid_q)
    );

    p_misalign_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> size_i);
    p_misalign_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> addr_o[0]);
    p_word_base_even_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i && !base_i[0]) |-> !misalign_o);
endmodule

// File: tb/test_agu_scaled.sv
module test_agu_scaled;
    typedef struct packed {
        logic        v;
        logic [15:0] a;
        logic        m;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] base_i = '0;
    logic [15:0] index_i = '0;
    logic [7:0]  imm_i = '0;
    logic        mode_i = 1'b0;
    logic        size_i = 1'b0;
    logic [15:0] addr_o, addr_q;
    logic        misalign_o, misalign_q, valid_q;

    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t q[$];
    logic [15:0] held_a = '0;
    logic        held_m = 1'b0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    agu_scaled i_agu_scaled (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .base_i(base_i), .index_i(index_i), .imm_i(imm_i),
        .mode_i(mode_i), .size_i(size_i),
        .addr_o(addr_o), .misalign_o(misalign_o),
        .addr_q(addr_q), .misalign_q(misalign_q), .valid_q(valid_q)
    );

    task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: apply one cycle of operands, check the combinational result, queue the registered one
    task automatic drive(input string req, input logic v, input logic [15:0] b,
                         input logic [15:0] x, input logic [7:0] im,
                         input logic md, input logic sz);
        logic [15:0] off, ea;
        logic        mis;
        @(negedge clk);
        in_valid = v; base_i = b; index_i = x; imm_i = im; mode_i = md; size_i = sz;
        off = md ? x : {{8{im[7]}}, im};
        if (sz) off = off * 16'd2;
        ea  = b + off;
        mis = sz & ea[0];
        #1;
        check(req, {1'b0, addr_o}, {1'b0, ea});
        check("R5", {16'd0, misalign_o}, {16'd0, mis});
        if (v) begin
            held_a = ea;
            held_m = mis;
        end
        q.push_back('{v: v, a: held_a, m: held_m});
    endtask

    // Monitor: after every edge compare the registered outputs with the oldest queued item
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(e.v ? "R7 valid" : "R8 valid", {16'd0, valid_q}, {16'd0, e.v});
            check(e.v ? "R7 addr" : "R8 addr", {1'b0, addr_q}, {1'b0, e.a});
            check(e.v ? "R7 mis" : "R8 mis", {16'd0, misalign_q}, {16'd0, e.m});
        end
    end

    initial begin
        #23;
        check("R9 valid", {16'd0, valid_q}, 17'd0);
        check("R9 addr", {1'b0, addr_q}, 17'd0);
        check("R9 mis", {16'd0, misalign_q}, 17'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R9 after release", {valid_q, addr_q}, 17'd0);
        drive("R1 positive imm", 1, 16'h1000, 16'h0000, 8'h05, 0, 0);
        drive("R1 negative imm", 1, 16'h1000, 16'h0000, 8'hFE, 0, 0);
        drive("R2 positive imm", 1, 16'h2000, 16'h0000, 8'h7F, 0, 1);
        drive("R2 minus two", 1, 16'h0100, 16'h0000, 8'hFE, 0, 1);
        drive("R3 index", 1, 16'h3000, 16'h0123, 8'h00, 1, 0);
        drive("R4 index", 1, 16'h3000, 16'h0123, 8'h00, 1, 1);
        drive("R4 top bit dropped", 1, 16'h0010, 16'h8001, 8'h00, 1, 1);
        drive("R8 idle", 0, 16'h5555, 16'h1111, 8'h11, 1, 1);
        drive("R8 idle again", 0, 16'h0001, 16'h0000, 8'h00, 0, 1);
        drive("R6 wrap imm", 1, 16'hFFFE, 16'h0000, 8'h02, 0, 1);
        drive("R6 wrap index", 1, 16'hFFF0, 16'h0020, 8'h00, 1, 0);
        drive("R6 wrap down", 1, 16'h0001, 16'h0000, 8'h80, 0, 1);
        drive("R5 odd word", 1, 16'h0101, 16'h0000, 8'h02, 0, 1);
        drive("R5 odd byte", 1, 16'h0101, 16'h0000, 8'h02, 0, 0);
        drive("R5 odd word idx", 1, 16'h0007, 16'h0003, 8'h00, 1, 1);
        drive("R8 hold odd", 0, 16'h0000, 16'h0000, 8'h00, 0, 0);
        drive("R1 final", 1, 16'h4242, 16'h0000, 8'h81, 0, 0);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule